// File: doc/BRIEF.md
# Sequential Radix-4 Booth Multiplier

This block multiplies two K-bit two's-complement numbers over several clock cycles. Each iteration consumes two bits of the multiplier through radix-4 Booth recoding, which gives a signed digit in {-2, -1, 0, +1, +2}. A selector turns that digit into the matching multiple of the multiplicand. Negative multiples come from bit inversion plus an injected carry, so there is no separate subtract path. The chosen multiple is merged into a running partial product through one row of 3:2 counters, and the partial product is held as a sum vector plus a carry vector. No carry ripples across the word during the iterations.

Two product bits become final in every iteration. A 2-bit adder with a small stored carry removes them from the redundant pair. Once all digits are consumed, one extra cycle runs a carry-propagate adder over the remaining upper part and registers the full 2K-bit product.

A client drives the operands, pulses `start` while the block is idle, and waits for the one-cycle `done` pulse. The product stays valid until the next operation completes.

Top module: `booth_seq_mul`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `busy` is 0, `done` is 0 and `product` is all zeros.
- R2: `start` sampled high while `busy` is 0 loads the operands, and `busy` is 1 from the next cycle on. The block performs N = ceil(K/2) iterations and then one final-add cycle. `done` is 1 in exactly the (N+2)-th cycle counted from the cycle in which `start` was sampled. In that cycle `busy` is already 0.
- R3: When `done` is 1, `product` equals the signed product of `mcand` and `mplier`, as a 2K-bit two's-complement value.
- R4: `done` stays high for exactly one cycle per operation.
- R5: `start` sampled while `busy` is 1 is ignored. The running operation finishes at its normal time with its original operands.
- R6: `product` changes only in cycles where `done` is 1. It holds its value while an operation runs and while the block is idle.
- R7: The Booth digit is taken from the bit triple (y[2j+1], y[2j], y[2j-1]), where y[-1]=0 and the multiplier is sign-extended to an even width. The mapping is: 000 or 111 gives 0; 001 or 010 gives +a; 011 gives +2a; 100 gives -2a; 101 or 110 gives -a. At most one magnitude (a or 2a) is selected, and negation is only ever applied to a nonzero magnitude.
- R8: Extreme operands give exact results. These are the most negative value squared (2^(2K-2)), the most negative value times the most positive value, and -1 times -1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication; honoured only while idle |
| mcand | input | K | Multiplicand, two's complement |
| mplier | input | K | Multiplier, two's complement |
| busy | output | 1 | Operation in progress (iterations and final add) |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 2K | Signed product, held until the next completion |

## Verification
Two events can land in one cycle: the completion pulse of one operation and the acceptance of the next `start`. The bench provokes this by raising `start` in the very cycle that `done` is high, for almost every operation. It then judges the second result by its value, by its latency measured from that cycle, and by the first product staying unchanged until the new completion. A second overlap is a `start` that arrives during the iterations with different operands. The bench judges it by an unchanged latency and a product that matches the original operands.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_ITER  = 2'd1,
        MS_FINAL = 2'd2
    } mul_state_e;

    // Signed Booth digit: magnitude one-hot in {one, two}, sign in neg
    typedef struct packed {
        logic neg;
        logic two;
        logic one;
    } booth_digit_t;

    function automatic booth_digit_t booth_recode(input logic [2:0] trip);
        booth_digit_t d;
        d = '0;
        case (trip)
            3'b001, 3'b010: d.one = 1'b1;
            3'b011:         d.two = 1'b1;
            3'b100: begin
                d.two = 1'b1;
                d.neg = 1'b1;
            end
            3'b101, 3'b110: begin
                d.one = 1'b1;
                d.neg = 1'b1;
            end
            default:        d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder (
    input  logic [2:0]                window,
    output booth_pkg::booth_digit_t   digit
);
    assign digit = booth_pkg::booth_recode(window);
endmodule

// File: rtl/booth_selector.sv
module booth_selector #(
    parameter int W = 32
) (
    input  logic [W-1:0]              mcand_al,
    input  logic [W-1:0]              live,
    input  booth_pkg::booth_digit_t   digit,
    output logic [W-1:0]              multiple,
    output logic                      cin_neg
);
    logic [W-1:0] mag;

    always_comb begin
        if (digit.two)      mag = mcand_al << 1;
        else if (digit.one) mag = mcand_al;
        else                mag = '0;
        // Inverted positions below the alignment point are dropped;
        // the +1 of the two's complement is returned through cin_neg.
        if (digit.neg) multiple = ~mag & live;
        else           multiple = mag;
        cin_neg = digit.neg;
    end
endmodule

// File: rtl/csa_row.sv
module csa_row #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] sum,
    output logic [W-1:0] carry
);
    assign carry[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_sum
        assign sum[i] = x[i] ^ y[i] ^ z[i];
    end

    for (genvar i = 0; i < W - 1; i++) begin : g_car
        assign carry[i+1] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
    end
endmodule

// File: rtl/cpa_adder.sv
module cpa_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [1:0]   cin,
    output logic [W-1:0] sum
);
    assign sum = x + y + W'(cin);
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul #(
    parameter int K = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [K-1:0]    mcand,
    input  logic [K-1:0]    mplier,
    output logic            busy,
    output logic            done,
    output logic [2*K-1:0]  product
);
    import booth_pkg::*;

    localparam int N  = (K + 1) / 2;     // iterations
    localparam int PW = 2 * K;           // product width
    localparam int LW = 2 * N;           // retired low bits
    localparam int UW = PW - LW;         // bits left for the final add
    localparam int CW = $clog2(N + 1);
    localparam int IW = $clog2(PW);

    mul_state_e      state_q;
    logic [CW-1:0]   cnt_q;
    logic [PW-1:0]   a_sh_q;
    logic [PW-1:0]   live_q;
    logic [LW:0]     ywin_q;
    logic [PW-1:0]   s_q, c_q;
    logic [1:0]      cf_q;
    logic [LW-1:0]   lo_q;
    logic [PW-1:0]   prod_q;
    logic            done_q;

    booth_digit_t    digit;
    logic [PW-1:0]   mult;
    logic            neg;
    logic [PW-1:0]   ns, nc;
    logic [PW-1:0]   win;
    logic [IW-1:0]   pos;
    logic [3:0]      r_sum;
    logic [UW-1:0]   upper;

    booth_recoder u_rec (
        .window (ywin_q[2:0]),
        .digit  (digit)
    );

    booth_selector #(.W(PW)) u_sel (
        .mcand_al (a_sh_q),
        .live     (live_q),
        .digit    (digit),
        .multiple (mult),
        .cin_neg  (neg)
    );

    csa_row #(.W(PW)) u_csa (
        .x     (s_q),
        .y     (c_q),
        .z     (mult),
        .sum   (ns),
        .carry (nc)
    );

    cpa_adder #(.W(UW)) u_cpa (
        .x   (s_q[PW-1:LW]),
        .y   (c_q[PW-1:LW]),
        .cin (cf_q),
        .sum (upper)
    );

    always_comb begin
        pos   = IW'(cnt_q) << 1;
        win   = live_q & ~(live_q << 2);
        r_sum = 4'(ns[pos +: 2]) + 4'(nc[pos +: 2]) + 4'(neg) + 4'(cf_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MS_IDLE;
            cnt_q   <= '0;
            a_sh_q  <= '0;
            live_q  <= '0;
            ywin_q  <= '0;
            s_q     <= '0;
            c_q     <= '0;
            cf_q    <= '0;
            lo_q    <= '0;
            prod_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                MS_IDLE: begin
                    if (start) begin
                        a_sh_q  <= PW'($signed(mcand));
                        live_q  <= '1;
                        ywin_q  <= {LW'($signed(mplier)), 1'b0};
                        s_q     <= '0;
                        c_q     <= '0;
                        cf_q    <= '0;
                        cnt_q   <= '0;
                        state_q <= MS_ITER;
                    end
                end
                MS_ITER: begin
                    s_q    <= ns & ~win;
                    c_q    <= nc & ~win;
                    cf_q   <= r_sum[3:2];
                    lo_q   <= {r_sum[1:0], lo_q[LW-1:2]};
                    a_sh_q <= a_sh_q << 2;
                    live_q <= live_q << 2;
                    ywin_q <= {{2{ywin_q[LW]}}, ywin_q[LW:2]};
                    cnt_q  <= cnt_q + 1'b1;
                    if (cnt_q == CW'(N - 1)) state_q <= MS_FINAL;
                end
                MS_FINAL: begin
                    prod_q  <= {upper, lo_q};
                    done_q  <= 1'b1;
                    state_q <= MS_IDLE;
                end
                default: state_q <= MS_IDLE;
            endcase
        end
    end

    assign busy    = (state_q != MS_IDLE);
    assign done    = done_q;
    assign product = prod_q;

endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
    parameter int K = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     busy,
    input  logic                     done,
    input  logic [2*K-1:0]           product,
    input  booth_pkg::booth_digit_t  digit
);
    localparam int N    = (K + 1) / 2;
    localparam int LATW = $clog2(N + 3);

    logic [LATW-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst)                 lat_q <= '0;
        else if (start && !busy) lat_q <= '0;
        else if (busy)           lat_q <= lat_q + 1'b1;
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_q == LATW'(N + 1)));

    // R2
    idle_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    product_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(product));

    // R7
    one_magnitude_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({digit.one, digit.two}));

    // R7
    neg_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        digit.neg |-> (digit.one || digit.two));

endmodule

bind booth_seq_mul booth_seq_mul_chk #(.K(K)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product),
    .digit   (digit)
);

// File: tb/sim_booth_seq_mul.sv
module sim_booth_seq_mul;
    localparam int K          = 16;
    localparam int N          = (K + 1) / 2;
    localparam int PW         = 2 * K;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [K-1:0]  mcand = '0;
    logic [K-1:0]  mplier = '0;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    booth_seq_mul #(.K(K)) u0 (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    function automatic logic [PW-1:0] ref_mul(input logic [K-1:0] a, input logic [K-1:0] b);
        logic signed [PW-1:0] ea, eb;
        ea = PW'($signed(a));
        eb = PW'($signed(b));
        return ea * eb;
    endfunction

    task automatic expect_eq(input string req, input string what,
                             input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge with the block idle or showing done.
    task automatic run_op(input logic [K-1:0] a, input logic [K-1:0] b,
                          input bit poke, input string req);
        logic [PW-1:0] held;
        int lat;
        bit hold_ok;
        held    = product;
        hold_ok = 1'b1;
        mcand   = a;
        mplier  = b;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        expect_eq("R2", "busy after start", PW'(busy), PW'(1));
        if (product !== held) hold_ok = 1'b0;
        lat = 1;
        while (!done && lat < 4 * N + 8) begin
            if (poke && lat == 3) begin
                mcand  = ~a;        // R5: must be ignored
                mplier = b ^ 16'h5A5A;
                start  = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
            if (!done && product !== held) hold_ok = 1'b0;
        end
        start = 1'b0;
        expect_eq(poke ? "R5" : "R2", "latency", PW'(lat), PW'(N + 2));
        expect_eq("R2", "busy at done", PW'(busy), PW'(0));
        expect_eq(req, "product", product, ref_mul(a, b));
        expect_eq("R6", "product held during run", PW'(hold_ok), PW'(1));
    endtask

    task automatic idle_gap(input int n);
        logic [PW-1:0] held;
        held = product;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            expect_eq("R4", "done after pulse", PW'(done), PW'(0));
            expect_eq("R6", "product held idle", product, held);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        rst = 1'b1;
        repeat (4) @(negedge clk);
        expect_eq("R1", "busy in reset", PW'(busy), PW'(0));
        expect_eq("R1", "done in reset", PW'(done), PW'(0));
        expect_eq("R1", "product in reset", product, '0);
        rst = 1'b0;
        @(negedge clk);
        expect_eq("R1", "busy after reset", PW'(busy), PW'(0));
        expect_eq("R1", "product after reset", product, '0);

        // R3 basic values
        run_op(16'd0, 16'd1234, 1'b0, "R3");
        run_op(16'd3, 16'd5, 1'b0, "R3");
        idle_gap(3);
        run_op(16'hFFFD, 16'd7, 1'b0, "R3");
        // R8 extremes
        run_op(16'h8000, 16'h8000, 1'b0, "R8");
        run_op(16'h8000, 16'h7FFF, 1'b0, "R8");
        run_op(16'hFFFF, 16'hFFFF, 1'b0, "R8");
        run_op(16'h7FFF, 16'h7FFF, 1'b0, "R8");
        // R7 multiplier patterns hitting every digit code
        run_op(16'h1357, 16'h5555, 1'b0, "R7");
        run_op(16'hB2C1, 16'hAAAA, 1'b0, "R7");
        run_op(16'h7FFF, 16'h3333, 1'b0, "R7");
        run_op(16'h8001, 16'hCCCC, 1'b0, "R7");
        run_op(16'h4E21, 16'h6B97, 1'b0, "R7");
        idle_gap(2);
        // R5 start while busy
        run_op(16'h1F2E, 16'hC0DE, 1'b1, "R5");
        run_op(16'h8000, 16'hFFFF, 1'b1, "R5");
        idle_gap(1);

        for (int i = 0; i < 80; i++) begin
            logic [K-1:0] ra, rb;
            ra = K'($urandom);
            rb = K'($urandom);
            run_op(ra, rb, ($urandom % 8) == 0, "R3");
            if (($urandom % 3) == 0) idle_gap(1 + ($urandom % 2));
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule